// File: doc/BRIEF.md
# Asynchronous NOR Flash Bus Bridge

This block lets a classic single-access Wishbone slave port reach an asynchronous parallel NOR flash with a 16-bit data bus. Each bus cycle turns into one or more timed flash accesses. Chip enable and the active strobe (output enable for reads, write enable for writes) stay low for a number of core clocks fixed by parameters. The bridge acknowledges the bus cycle once the last strobe has ended.

A full-word read is split into two half-word flash reads at consecutive flash addresses, and the two halves are joined into one 32-bit word. A processor can therefore fetch instructions straight from the flash. Command sequences such as unlock, erase or program are built by software from plain half-word writes. The bridge only times the bus. It has no burst or page mode.

The Wishbone address port carries the byte address without its bit 0. Since the flash works in 16-bit units, this field is the flash word address unchanged.

Top module: `nor_async_bridge`

## Requirements
- R1: The flash address of an access equals `wb_adr_i` (the byte address shifted right by one). The second half of a full-word read uses that address plus one.
- R2: Every flash read holds `fl_ce_n_o` and `fl_oe_n_o` low together for exactly RD_CYCLES consecutive clocks, with `fl_we_n_o` high. The read data is taken from `fl_dq_i` on the last clock of that window.
- R3: Every flash write holds `fl_ce_n_o` and `fl_we_n_o` low together for exactly WR_CYCLES consecutive clocks, and `fl_oe_n_o` stays high throughout.
- R4: A read with `wb_sel_i` = 4'b1111 performs two flash reads. The half-word from the lower flash address goes to `wb_dat_o[31:16]` and the one from the next address goes to `wb_dat_o[15:0]`. ACK comes only after both reads.
- R5: A read with any other select value performs one flash read and returns the half-word on both `wb_dat_o[31:16]` and `wb_dat_o[15:0]`.
- R6: A write drives `fl_dq_o` from `wb_dat_i[31:16]` when `wb_sel_i[3]` or `wb_sel_i[2]` is set, and from `wb_dat_i[15:0]` otherwise. Every write, including one with all four select bits set, is a single flash access.
- R7: `fl_ce_n_o` returns high for at least one clock between any two flash accesses, including the two halves of a full-word read.
- R8: `fl_dq_oe_o` (1 = drive, 0 = high impedance) is high only while `fl_we_n_o` is low.
- R9: ACK is a one-clock pulse in the clock after the last strobe ends. A read therefore takes RD_CYCLES+1 clocks from acceptance to ACK, a write WR_CYCLES+1 and a full-word read 2*RD_CYCLES+2. A new access starts only when CYC and STB are both high. A request held high across an ACK is taken as a new cycle two clocks after that ACK.
- R10: While `rst_i` is high, `fl_ce_n_o`, `fl_oe_n_o` and `fl_we_n_o` are high, and `wb_ack_o` and `fl_dq_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; all flash timing is counted on it |
| rst_i | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_sel_i | input | 4 | Byte lane selects |
| wb_adr_i | input | WB_ADR_W-1 | Byte address bits [WB_ADR_W-1:1] |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ACK |
| wb_ack_o | output | 1 | One-clock acknowledge |
| fl_adr_o | output | WB_ADR_W-1 | Flash word address |
| fl_dq_i | input | 16 | Data from flash |
| fl_dq_o | output | 16 | Data to flash |
| fl_dq_oe_o | output | 1 | Data drive enable (0 = high impedance) |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |

## Verification
Two events can fall in the same clock: the ACK of one access and a request for the next one, when the master keeps CYC and STB high across the ACK. The bench provokes this by leaving the strobe up at the ACK and switching a read into a write in that cycle. It judges the result by four things: exactly two ACK pulses, the second one WR_CYCLES+2 clocks after the first, a chip-enable gap that splits the two accesses into separate runs of the right lengths, and the write reaching the new address with the new data.

// File: rtl/nor_bridge_pkg.sv
package nor_bridge_pkg;

    // Bridge sequencing states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2,
        ST_DONE   = 2'd3
    } br_state_e;

endpackage

// File: rtl/nor_strobe_timer.sv
module nor_strobe_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R2: the hold counter never wraps below zero
    assert_no_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

    // R2: without a reload the counter steps down by exactly one
    assert_count_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/nor_lane_unit.sv
module nor_lane_unit (
    input  logic [3:0]  sel_i,
    input  logic [31:0] wdat_i,
    input  logic        dual_i,
    input  logic [15:0] hi_i,
    input  logic [15:0] lo_i,
    output logic [15:0] wr_half_o,
    output logic [31:0] rd_word_o
);

    // Write lane: the upper half wins whenever one of its bytes is selected
    always_comb begin
        if (sel_i[3] || sel_i[2]) begin
            wr_half_o = wdat_i[31:16];
        end else begin
            wr_half_o = wdat_i[15:0];
        end
    end

    // Read assembly: lower flash address lands in the upper half
    always_comb begin
        if (dual_i) begin
            rd_word_o = {hi_i, lo_i};
        end else begin
            rd_word_o = {lo_i, lo_i};
        end
    end

endmodule

// File: rtl/nor_async_bridge.sv
module nor_async_bridge
    import nor_bridge_pkg::*;
#(
    parameter int WB_ADR_W  = 26,
    parameter int RD_CYCLES = 5,
    parameter int WR_CYCLES = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  wb_cyc_i,
    input  logic                  wb_stb_i,
    input  logic                  wb_we_i,
    input  logic [3:0]            wb_sel_i,
    input  logic [WB_ADR_W-1:1]   wb_adr_i,
    input  logic [31:0]           wb_dat_i,
    output logic [31:0]           wb_dat_o,
    output logic                  wb_ack_o,
    output logic [WB_ADR_W-2:0]   fl_adr_o,
    input  logic [15:0]           fl_dq_i,
    output logic [15:0]           fl_dq_o,
    output logic                  fl_dq_oe_o,
    output logic                  fl_ce_n_o,
    output logic                  fl_oe_n_o,
    output logic                  fl_we_n_o
);

    localparam int FL_ADR_W = WB_ADR_W - 1;
    localparam int MAX_CYC  = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);

    typedef struct packed {
        br_state_e             st;
        logic [FL_ADR_W-1:0]   adr;
        logic                  wr;
        logic                  dual;
        logic                  second;
        logic [15:0]           wdat;
        logic [15:0]           hi;
        logic [31:0]           rdat;
        logic                  ce_n;
        logic                  oe_n;
        logic                  we_n;
        logic                  dq_oe;
        logic                  ack;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [15:0]      lane_wdat;
    logic [31:0]      lane_rword;

    nor_strobe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    nor_lane_unit u_lanes (
        .sel_i     (wb_sel_i),
        .wdat_i    (wb_dat_i),
        .dual_i    (r_q.dual),
        .hi_i      (r_q.hi),
        .lo_i      (fl_dq_i),
        .wr_half_o (lane_wdat),
        .rd_word_o (lane_rword)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = RD_LOAD;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wb_cyc_i && wb_stb_i) begin
                    r_d.adr    = wb_adr_i;
                    r_d.wr     = wb_we_i;
                    r_d.dual   = !wb_we_i && (wb_sel_i == 4'hF);
                    r_d.second = 1'b0;
                    r_d.wdat   = lane_wdat;
                    r_d.ce_n   = 1'b0;
                    r_d.oe_n   = wb_we_i;
                    r_d.we_n   = !wb_we_i;
                    r_d.dq_oe  = wb_we_i;
                    tmr_load   = 1'b1;
                    tmr_val    = wb_we_i ? WR_LOAD : RD_LOAD;
                    r_d.st     = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    if (r_q.dual && !r_q.second) begin
                        r_d.hi = fl_dq_i;
                        r_d.st = ST_GAP;
                    end else begin
                        if (!r_q.wr) begin
                            r_d.rdat = lane_rword;
                        end
                        r_d.ack = 1'b1;
                        r_d.st  = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                r_d.adr    = r_q.adr + FL_ADR_W'(1);
                r_d.second = 1'b1;
                r_d.ce_n   = 1'b0;
                r_d.oe_n   = 1'b0;
                tmr_load   = 1'b1;
                tmr_val    = RD_LOAD;
                r_d.st     = ST_STROBE;
            end
            ST_DONE: begin
                r_d.ack = 1'b0;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_dat_o   = r_q.rdat;
    assign wb_ack_o   = r_q.ack;
    assign fl_adr_o   = r_q.adr;
    assign fl_dq_o    = r_q.wdat;
    assign fl_dq_oe_o = r_q.dq_oe;
    assign fl_ce_n_o  = r_q.ce_n;
    assign fl_oe_n_o  = r_q.oe_n;
    assign fl_we_n_o  = r_q.we_n;

    // R9: acknowledge lasts exactly one clock
    assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_ack_o |=> !wb_ack_o);

    // R7: the chip is deselected whenever the cycle is acknowledged
    assert_ack_deselect_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_ack_o |-> fl_ce_n_o);

    // R2, R3: a strobe only appears under chip enable, never both strobes at once
    assert_strobe_under_ce_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!fl_oe_n_o || !fl_we_n_o) |-> !fl_ce_n_o);
    assert_strobes_exclusive_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(!fl_oe_n_o && !fl_we_n_o));

    // R8: data is driven only under the write strobe
    assert_drive_in_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        fl_dq_oe_o |-> !fl_we_n_o);

    // R1: the second half of a full-word read follows the first at address plus one
    assert_next_half_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(fl_ce_n_o) && $past(r_q.st) == ST_GAP) |-> (fl_adr_o == $past(fl_adr_o) + FL_ADR_W'(1)));

endmodule

// File: tb/tb_nor_async_bridge.sv
`timescale 1ns/1ps
module tb_nor_async_bridge;

    localparam int WB_ADR_W = 26;
    localparam int RD_CYC   = 5;
    localparam int WR_CYC   = 3;
    localparam int NVEC     = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we_i = 1'b0;
    logic [3:0]  sel_i = 4'h0;
    logic [WB_ADR_W-1:1] adr_i = '0;
    logic [31:0] dat_i = '0;
    logic [31:0] dat_o;
    logic        ack;
    logic [24:0] fl_adr;
    logic [15:0] dq_in, dq_out;
    logic        dq_oe, ce_n, oe_n, we_n;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    nor_async_bridge #(.WB_ADR_W(WB_ADR_W), .RD_CYCLES(RD_CYC), .WR_CYCLES(WR_CYC)) dut (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we_i),
        .wb_sel_i(sel_i), .wb_adr_i(adr_i), .wb_dat_i(dat_i), .wb_dat_o(dat_o),
        .wb_ack_o(ack), .fl_adr_o(fl_adr), .fl_dq_i(dq_in), .fl_dq_o(dq_out),
        .fl_dq_oe_o(dq_oe), .fl_ce_n_o(ce_n), .fl_oe_n_o(oe_n), .fl_we_n_o(we_n)
    );

    function automatic logic [15:0] fmodel(input logic [24:0] a);
        logic [24:0] m;
        m = a * 25'd40503;
        return m[15:0] ^ 16'h5A3C;
    endfunction

    // flash read model: data only while selected and output enabled
    assign dq_in = (!ce_n && !oe_n) ? fmodel(fl_adr) : 16'hDEAD;

    // bus monitor: one log entry per chip-enable low run
    int          run = 0;
    int          n_acc = 0;
    int          ack_pulses = 0;
    int          oe_viol = 0;
    logic [24:0] cur_adr;
    logic        cur_wr, cur_bad;
    logic [15:0] cur_wd;
    int          acc_len [64];
    logic [24:0] acc_adr [64];
    logic        acc_wr  [64];
    logic        acc_bad [64];
    logic [15:0] acc_wd  [64];

    always @(negedge clk) begin
        if (!rst) begin
            if (ack) ack_pulses++;
            if (dq_oe && we_n) oe_viol++;
            if (!ce_n) begin
                if (run == 0) begin
                    cur_adr = fl_adr; cur_wr = !we_n; cur_bad = 1'b0;
                end
                run++;
                if (!we_n) cur_wd = dq_out;
                if (cur_wr ? (we_n || !oe_n) : (oe_n || !we_n)) cur_bad = 1'b1;
            end else if (run > 0) begin
                acc_len[n_acc % 64] = run;
                acc_adr[n_acc % 64] = cur_adr;
                acc_wr[n_acc % 64]  = cur_wr;
                acc_bad[n_acc % 64] = cur_bad;
                acc_wd[n_acc % 64]  = cur_wd;
                n_acc++;
                run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input logic [3:0] s, input logic [25:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we_i = w; sel_i = s; adr_i = a[25:1]; dat_i = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 200);
        rd = dat_o;
        cyc = 1'b0; stb = 1'b0; we_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // vector: {we, sel, byte address, write data}
    localparam logic [62:0] VEC [NVEC] = '{
        {1'b0, 4'hF, 26'h0000100, 32'h0},
        {1'b0, 4'hC, 26'h0000202, 32'h0},
        {1'b0, 4'hF, 26'h3FFFFFC, 32'h0},
        {1'b1, 4'hC, 26'h0001000, 32'hA5C3_1234},
        {1'b1, 4'h3, 26'h0001002, 32'hBEEF_4321},
        {1'b1, 4'hF, 26'h0002000, 32'h1357_9BDF},
        {1'b0, 4'h1, 26'h0ABCDE1, 32'h0},
        {1'b0, 4'hF, 26'h1FFFFFC, 32'h0},
        {1'b1, 4'h8, 26'h2468ACE, 32'h7E81_0000}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int lat, lat2, base, abase;
        logic [24:0] fa;
        logic [31:0] exp_rd;
        int exp_n, exp_lat;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(ce_n == 1'b1, "R10", "ce_n in reset", 32'(ce_n), 1);
        check(oe_n == 1'b1, "R10", "oe_n in reset", 32'(oe_n), 1);
        check(we_n == 1'b1, "R10", "we_n in reset", 32'(we_n), 1);
        check(ack == 1'b0, "R10", "ack in reset", 32'(ack), 0);
        check(dq_oe == 1'b0, "R10", "dq_oe in reset", 32'(dq_oe), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic        vw;
            logic [3:0]  vs;
            logic [25:0] va;
            logic [31:0] vd;
            {vw, vs, va, vd} = VEC[v];
            fa = va[25:1];
            base = n_acc; abase = ack_pulses;
            xfer(vw, vs, va, vd, rd, lat);
            exp_n   = (!vw && vs == 4'hF) ? 2 : 1;
            exp_lat = vw ? WR_CYC + 1 : (exp_n == 2 ? 2 * RD_CYC + 2 : RD_CYC + 1);
            check(lat == exp_lat, "R9", "ack latency", 32'(lat), 32'(exp_lat));
            check(ack_pulses - abase == 1, "R9", "ack pulses", 32'(ack_pulses - abase), 1);
            check(n_acc - base == exp_n, "R4", "access count", 32'(n_acc - base), 32'(exp_n));
            check(acc_adr[base % 64] == fa, "R1", "flash address", 32'(acc_adr[base % 64]), 32'(fa));
            check(!acc_bad[base % 64], "R7", "strobe/ce pairing", 32'(acc_bad[base % 64]), 0);
            if (vw) begin
                check(acc_wr[base % 64] == 1'b1, "R3", "access is write", 32'(acc_wr[base % 64]), 1);
                check(acc_len[base % 64] == WR_CYC, "R3", "write strobe length",
                      32'(acc_len[base % 64]), 32'(WR_CYC));
                check(acc_wd[base % 64] == ((vs[3] || vs[2]) ? vd[31:16] : vd[15:0]), "R6",
                      "write lane", 32'(acc_wd[base % 64]),
                      32'((vs[3] || vs[2]) ? vd[31:16] : vd[15:0]));
            end else begin
                check(acc_len[base % 64] == RD_CYC, "R2", "read strobe length",
                      32'(acc_len[base % 64]), 32'(RD_CYC));
                if (exp_n == 2) begin
                    check(acc_len[(base + 1) % 64] == RD_CYC, "R7", "second read separate run",
                          32'(acc_len[(base + 1) % 64]), 32'(RD_CYC));
                    check(acc_adr[(base + 1) % 64] == fa + 25'd1, "R1", "second half address",
                          32'(acc_adr[(base + 1) % 64]), 32'(fa + 25'd1));
                    exp_rd = {fmodel(fa), fmodel(fa + 25'd1)};
                    check(rd == exp_rd, "R4", "full-word read data", rd, exp_rd);
                end else begin
                    exp_rd = {fmodel(fa), fmodel(fa)};
                    check(rd == exp_rd, "R5", "half-word read data", rd, exp_rd);
                end
            end
        end
        check(oe_viol == 0, "R8", "data driven outside write", 32'(oe_viol), 0);

        // R9: CYC or STB alone starts nothing
        base = n_acc; abase = ack_pulses;
        @(negedge clk); cyc = 1'b1; stb = 1'b0;
        repeat (8) @(negedge clk);
        cyc = 1'b0; stb = 1'b1;
        repeat (8) @(negedge clk);
        stb = 1'b0;
        repeat (2) @(negedge clk);
        check(n_acc == base, "R9", "accesses without full request", 32'(n_acc - base), 0);
        check(ack_pulses == abase, "R9", "acks without full request", 32'(ack_pulses - abase), 0);

        // ACK and a held request in the same cycle: read then write back to back
        base = n_acc; abase = ack_pulses;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we_i = 1'b0; sel_i = 4'h3; adr_i = 25'h0000321; dat_i = '0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!ack && lat < 200);
        rd = dat_o;
        we_i = 1'b1; sel_i = 4'h3; adr_i = 25'h0000400; dat_i = 32'h0000_C0DE;
        lat2 = 0;
        do begin @(negedge clk); lat2++; end while (!ack && lat2 < 200);
        cyc = 1'b0; stb = 1'b0; we_i = 1'b0;
        repeat (2) @(negedge clk);
        check(lat == RD_CYC + 1, "R9", "first ack latency", 32'(lat), 32'(RD_CYC + 1));
        check(lat2 == WR_CYC + 2, "R9", "held request ack distance", 32'(lat2), 32'(WR_CYC + 2));
        check(ack_pulses - abase == 2, "R9", "back-to-back ack pulses", 32'(ack_pulses - abase), 2);
        check(rd == {fmodel(25'h321), fmodel(25'h321)}, "R5", "back-to-back read data",
              rd, {fmodel(25'h321), fmodel(25'h321)});
        check(n_acc - base == 2, "R7", "two separate ce runs", 32'(n_acc - base), 2);
        check(acc_len[base % 64] == RD_CYC && acc_len[(base + 1) % 64] == WR_CYC, "R7",
              "run lengths", 32'(acc_len[(base + 1) % 64]), 32'(WR_CYC));
        check(acc_wr[(base + 1) % 64] && acc_adr[(base + 1) % 64] == 25'h400, "R1",
              "held write address", 32'(acc_adr[(base + 1) % 64]), 32'h400);
        check(acc_wd[(base + 1) % 64] == 16'hC0DE, "R6", "held write data",
              32'(acc_wd[(base + 1) % 64]), 32'hC0DE);
        check(oe_viol == 0, "R8", "data driven outside write", 32'(oe_viol), 0);

        // R10: reset in the middle of an access returns the bus to idle
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we_i = 1'b1; sel_i = 4'hC; adr_i = 25'h10; dat_i = 32'h1111_2222;
        repeat (2) @(negedge clk);
        rst = 1'b1; cyc = 1'b0; stb = 1'b0; we_i = 1'b0;
        @(negedge clk);
        check(ce_n && oe_n && we_n && !dq_oe && !ack, "R10", "reset mid-access",
              32'({ce_n, oe_n, we_n, dq_oe, ack}), 32'b11100);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule